// File: doc/BRIEF.md
# Statically Scheduled Tile Crossbar Router

Each tile of a mesh of mixed cores carries one of these routers. It has five input ports and five output ports: four toward the neighbouring tiles (north, south, east, west) and one toward the local core. A full crossbar joins them. A small sequencer chooses the crossbar setting on every cycle. It steps a program counter through a local schedule memory, and each word in that memory names the source of every output. Nothing arbitrates at run time. Each transfer follows a precomputed pattern that repeats forever, so the latency through the tile is known in advance.

The schedule is loaded through a configuration write port while the router is stopped. When the run enable rises, the router executes words 0 through a programmable last index. Each word is held for a programmed number of cycles, and then the sequence starts again at word 0. Every output has a register, which forms the pipeline stage on the link toward the next tile. The valid flag passes through the crossbar together with its data.

Top module: `tile_sched_xbar`

## Requirements
- R1: While reset is active, and afterwards until the first routed cycle, every `out_valid` bit is 0 and every `out_data` lane is 0. Reset is asserted asynchronously, and its release takes effect two clock edges after `rst_n` rises.
- R2: A schedule word has 19 bits. Bits [2:0] select the source for the north output, [5:3] for south, [8:6] for east, [11:9] for west and [14:12] for the core output. Bits [18:15] hold the repeat count. Port index p uses lane p of the packed buses: `in_data[16p+15:16p]`, `in_valid[p]`, and the same on the output side, with 0 = north, 1 = south, 2 = east, 3 = west, 4 = core.
- R3: Select codes 0 to 4 name the input port of the same index. On the clock edge where such a word is current, the output register loads that input's data and valid. The output therefore shows them one cycle after they are presented.
- R4: Select codes 5, 6 and 7 mean idle. An idle output drives valid 0 on the next cycle and keeps its previous data.
- R5: A word whose repeat count is r stays current for r+1 consecutive running cycles. The next word then follows.
- R6: After the word at `last_idx` has used up its repeat count, the schedule returns to word 0. A `last_idx` of 0 runs word 0 alone.
- R7: One cycle after `run_en` is low, all outputs are invalid and all data is held. While stopped, the schedule is held at word 0, so every rising edge of `run_en` begins with word 0 and repeat position 0.
- R8: A configuration write (`cfg_we`, `cfg_addr`, `cfg_wdata`) takes effect only in a cycle in which `run_en` is low. A write in any cycle with `run_en` high is dropped, and that includes the very cycle in which `run_en` rises.
- R9: Several outputs may name the same input in one word. Each of them then receives that input's data and valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High to execute the schedule, low to stop and allow loading |
| last_idx | input | 4 | Index of the final schedule word before returning to 0 |
| cfg_we | input | 1 | Schedule write strobe |
| cfg_addr | input | 4 | Schedule word address |
| cfg_wdata | input | 19 | Schedule word to write |
| in_data | input | 80 | Five 16-bit input lanes (N, S, E, W, core) |
| in_valid | input | 5 | Valid flag of each input lane |
| out_data | output | 80 | Five 16-bit registered output lanes (N, S, E, W, core) |
| out_valid | output | 5 | Valid flag of each output lane |

## Verification
Two functions can land on the same clock edge: a configuration write and the rise of `run_en`, which restarts the schedule at word 0. The bench raises `run_en` in the same cycle as a write that would make word 0 fully idle. It then expects the first routed cycle, and the later return to word 0 after the wrap, to still follow the old word 0. A second collision comes when the repeat count runs out on the final word: the advance and the wrap to 0 happen together. The table walks through several such wraps, and the bench judges each one by comparing the routed lanes against the word it expects.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // port order shared by every lane bus: north, south, east, west, core
  localparam int NPORT = 5;
  localparam int SEL_W = 3;
  localparam int SEL_FIELDS_W = NPORT * SEL_W;
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NPORT - 1);

  typedef enum logic [SEL_W-1:0] {
    SRC_NORTH = 3'd0,
    SRC_SOUTH = 3'd1,
    SRC_EAST  = 3'd2,
    SRC_WEST  = 3'd3,
    SRC_CORE  = 3'd4,
    SRC_IDLE  = 3'd5
  } src_sel_e;

  function automatic logic sel_live(input logic [SEL_W-1:0] sel);
    return sel <= SEL_LAST;
  endfunction
endpackage

// File: rtl/xbar_imem.sv
module xbar_imem #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 19
) (
  input  logic              clk,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic              wr_ok;

  // R8: loading is only possible while the schedule is stopped
  assign wr_ok = wr_en & ~run_en;

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/xbar_seq.sv
module xbar_seq #(
  parameter int ADDR_W = 4,
  parameter int RPT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [ADDR_W-1:0] last_idx,
  input  logic [RPT_W-1:0]  rpt,
  output logic [ADDR_W-1:0] pc,
  output logic [RPT_W-1:0]  cnt
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [RPT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    pc_d  = pc_q;
    cnt_d = cnt_q;
    if (!run_en) begin
      // R7: parked at word 0 so each start is aligned
      pc_d  = '0;
      cnt_d = '0;
    end else if (cnt_q == rpt) begin
      cnt_d = '0;
      pc_d  = (pc_q == last_idx) ? '0 : pc_q + 1'b1;  // R6 wrap, R5 advance
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      pc_q  <= pc_d;
      cnt_q <= cnt_d;
    end
  end

  assign pc  = pc_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_en,
  input  logic [SEL_FIELDS_W-1:0]   sel_flat,
  input  logic [NPORT*DATA_W-1:0]   in_data,
  input  logic [NPORT-1:0]          in_valid,
  output logic [NPORT*DATA_W-1:0]   out_data,
  output logic [NPORT-1:0]          out_valid
);
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] src_d;
    logic              src_v;
    logic              live;
    logic              valid_d;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;

    assign sel = sel_flat[o*SEL_W +: SEL_W];

    always_comb begin
      src_d = '0;
      src_v = 1'b0;
      for (int k = 0; k < NPORT; k++) begin
        if (sel == SEL_W'(k)) begin
          src_d = in_data[k*DATA_W +: DATA_W];
          src_v = in_valid[k];
        end
      end
      live    = run_en & sel_live(sel);
      valid_d = live & src_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q  <= '0;
        valid_q <= 1'b0;
      end else begin
        valid_q <= valid_d;
        if (live) begin
          data_q <= src_d;
        end
      end
    end

    assign out_data[o*DATA_W +: DATA_W] = data_q;
    assign out_valid[o]                 = valid_q;
  end
endmodule

// File: rtl/tile_sched_xbar.sv
module tile_sched_xbar
  import xbar_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int RPT_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run_en,
  input  logic [ADDR_W-1:0]             last_idx,
  input  logic                          cfg_we,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [SEL_FIELDS_W+RPT_W-1:0] cfg_wdata,
  input  logic [NPORT*DATA_W-1:0]       in_data,
  input  logic [NPORT-1:0]              in_valid,
  output logic [NPORT*DATA_W-1:0]       out_data,
  output logic [NPORT-1:0]              out_valid
);
  localparam int WORD_W = SEL_FIELDS_W + RPT_W;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [ADDR_W-1:0] pc;
  logic [RPT_W-1:0]  cnt;
  logic [WORD_W-1:0] cur_inst;
  logic [RPT_W-1:0]  cur_rpt;
  logic [SEL_FIELDS_W-1:0] cur_sel;

  // R1: asynchronous assertion, release after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  // R2: word layout, repeat count on top, select fields below
  assign cur_rpt = cur_inst[WORD_W-1 -: RPT_W];
  assign cur_sel = cur_inst[SEL_FIELDS_W-1:0];

  xbar_imem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_imem (
    .clk     (clk),
    .run_en  (run_en),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .rd_addr (pc),
    .rd_data (cur_inst)
  );

  xbar_seq #(.ADDR_W(ADDR_W), .RPT_W(RPT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run_en   (run_en),
    .last_idx (last_idx),
    .rpt      (cur_rpt),
    .pc       (pc),
    .cnt      (cnt)
  );

  xbar_switch #(.DATA_W(DATA_W)) u_switch (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run_en    (run_en),
    .sel_flat  (cur_sel),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .out_data  (out_data),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/tile_sched_xbar_chk.sv
module tile_sched_xbar_chk
  import xbar_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int RPT_W  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          run_en,
  input logic [ADDR_W-1:0]             last_idx,
  input logic [ADDR_W-1:0]             pc,
  input logic [RPT_W-1:0]              cnt,
  input logic [SEL_FIELDS_W+RPT_W-1:0] cur_inst,
  input logic [NPORT-1:0]              out_valid
);
  localparam int WORD_W = SEL_FIELDS_W + RPT_W;

  logic [RPT_W-1:0] rpt;
  assign rpt = cur_inst[WORD_W-1 -: RPT_W];

  p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (out_valid == '0));

  p_restart_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (pc == '0 && cnt == '0));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && pc == last_idx && cnt == rpt) |=> (pc == '0));

  p_repeat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cnt != rpt) |=> $stable(pc));

  p_frozen_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cnt != rpt) |=> $stable(cur_inst));

  for (genvar o = 0; o < NPORT; o++) begin : g_idle
    p_idle_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !sel_live(cur_inst[o*SEL_W +: SEL_W])) |=> !out_valid[o]);
  end
endmodule

bind tile_sched_xbar tile_sched_xbar_chk #(.ADDR_W(ADDR_W), .RPT_W(RPT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .run_en    (run_en),
  .last_idx  (last_idx),
  .pc        (pc),
  .cnt       (cnt),
  .cur_inst  (cur_inst),
  .out_valid (out_valid)
);

// File: tb/tile_sched_xbar_bench.sv
module tile_sched_xbar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NP = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run_en;
  logic [3:0]    last_idx;
  logic          cfg_we;
  logic [3:0]    cfg_addr;
  logic [18:0]   cfg_wdata;
  logic [NP*DW-1:0] in_data;
  logic [NP-1:0] in_valid;
  logic [NP*DW-1:0] out_data;
  logic [NP-1:0] out_valid;

  tile_sched_xbar u_tile_sched_xbar (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .last_idx(last_idx),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [18:0]   prog [4];
  logic [NP*DW-1:0] exp_d;
  logic [NP-1:0] exp_v;
  int stamp = 0;
  int mpc = 0;
  int mcnt = 0;

  // R2 word builder: {repeat, core, west, east, south, north}
  function automatic logic [18:0] mk(int n, int s, int e, int w, int c, int r);
    return {4'(r), 3'(c), 3'(w), 3'(e), 3'(s), 3'(n)};
  endfunction

  // table: {input valid mask, expected schedule word}
  localparam logic [7:0] VEC [12] = '{
    {5'b11111, 3'd0}, {5'b11111, 3'd1}, {5'b01111, 3'd1}, {5'b11011, 3'd2},
    {5'b11110, 3'd3}, {5'b10101, 3'd0}, {5'b10000, 3'd1}, {5'b11111, 3'd1},
    {5'b00100, 3'd2}, {5'b11111, 3'd3}, {5'b01010, 3'd0}, {5'b11111, 3'd1}
  };

  task automatic check(input string req);
    n_vec++;
    if (out_valid !== exp_v || out_data !== exp_d) begin
      n_bad++;
      $display("FAIL %s: valid=%b data=%h expected valid=%b data=%h",
               req, out_valid, out_data, exp_v, exp_d);
    end
  endtask

  // one clock: drive inputs, predict, sample after the edge
  task automatic run_step(input logic run, input logic [NP-1:0] mask,
                          input int idx, input string req);
    logic [2:0] sel;
    run_en   = run;
    in_valid = mask;
    for (int p = 0; p < NP; p++) in_data[p*DW +: DW] = {4'(p+1), 4'hA, 8'(stamp)};
    for (int o = 0; o < NP; o++) begin
      if (!run) begin
        exp_v[o] = 1'b0;
      end else begin
        sel = prog[idx][o*3 +: 3];
        if (sel <= 3'd4) begin
          exp_v[o] = mask[sel];
          exp_d[o*DW +: DW] = in_data[sel*DW +: DW];
        end else begin
          exp_v[o] = 1'b0;
        end
      end
    end
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    stamp++;
    check(req);
  endtask

  // schedule follower derived from R5, R6 and R7
  task automatic model_step(input logic run, input logic [NP-1:0] mask, input string req);
    int r;
    if (!run) begin
      run_step(1'b0, mask, 0, req);
      mpc = 0; mcnt = 0;
    end else begin
      run_step(1'b1, mask, mpc, req);
      r = int'(prog[mpc][18:15]);
      if (mcnt == r) begin
        mcnt = 0;
        mpc = (mpc == int'(last_idx)) ? 0 : mpc + 1;
      end else begin
        mcnt++;
      end
    end
  endtask

  task automatic load(input int addr, input logic [18:0] w);
    run_en = 1'b0; cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = w;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    if (addr < 4) prog[addr] = w;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; last_idx = 4'd3; cfg_we = 1'b0;
    cfg_addr = '0; cfg_wdata = '0; in_data = '0; in_valid = '0;
    exp_v = '0; exp_d = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 after release");

    // swap pairs, core broadcast (R9), partly idle with codes 5-7, north broadcast
    load(0, mk(1, 0, 3, 2, 7, 0));
    load(1, mk(4, 4, 4, 4, 4, 1));
    load(2, mk(5, 2, 6, 7, 0, 0));
    load(3, mk(0, 0, 0, 0, 4, 0));

    // R3 R4 R5 R6 R9: table walk from a fresh start
    for (int i = 0; i < 12; i++) begin
      run_step(1'b1, VEC[i][7:3], int'(VEC[i][2:0]), "R3/R5/R6 table");
    end

    // R7: stop holds data and drops valid
    model_step(1'b0, 5'b11111, "R7 stopped");
    model_step(1'b0, 5'b11111, "R7 stopped");

    // R8: write in the rise cycle is dropped; restart begins at word 0 (R7)
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = mk(7, 7, 7, 7, 7, 0);
    model_step(1'b1, 5'b11111, "R8 rise-cycle write");
    for (int i = 0; i < 4; i++) model_step(1'b1, 5'b11111, "R5/R6 after restart");
    model_step(1'b1, 5'b11111, "R6 wrap to word 0");
    // R8: write while running is dropped
    cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = mk(7, 7, 7, 7, 7, 0);
    model_step(1'b1, 5'b10111, "R8 running write");
    for (int i = 0; i < 5; i++) model_step(1'b1, 5'b11011, "R8 old word kept");

    // R8: stopped write accepted; R6: single-word schedule; R5: repeat 2
    model_step(1'b0, 5'b11111, "R7 stopped");
    load(0, mk(3, 4, 7, 6, 3, 2));
    last_idx = 4'd0;
    for (int i = 0; i < 7; i++) model_step(1'b1, 5'b11111, "R6/R8 single word");
    model_step(1'b0, 5'b11111, "R7 final stop");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule